// File: doc/BRIEF.md
# Bus Loader and Packet Front-End for a Spiking Crossbar

This block is the bus-facing front of a crossbar core that connects a set of input axons to a set of neurons. A 32-bit bus master fills two internal stores with single-word writes. The first is the connection matrix, with one row of neuron-wide bits per axon. The second holds one 80-bit parameter record per neuron. The core reads the parameter store through a dedicated registered read port.

Once the stores are loaded, the master drives the computation with bus reads alone. A read at the base of a matrix row is an input spike for that axon. The block answers it with a one-cycle packet strobe, the axon index and the whole stored row. Reads at two fixed control addresses mark the start and the end of an image. A small read-only window returns the neurons' current spike vector, which the core supplies on an input port.

The master may hold a request for a single clock without waiting for acknowledge. For that reason the block captures the address and data on the cycle the strobe is seen, and it acknowledges every request exactly one cycle later.

Top module: `xbar_bus_frontend`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wb_ack_o`, `pkt_valid_o`, `img_start_o`, `img_end_o`, `pkt_axon_o` and `wb_dat_o` are zero. A request made during reset is not acknowledged.
- R2: Every cycle with `wb_cyc_i` and `wb_stb_i` both high is one request, and it is acknowledged by `wb_ack_o` in the following cycle only. A cycle without a request produces no acknowledge in the next cycle.
- R3: A write with nonzero `wb_sel_i` to 0x30000000 + r*32 + s*4 (s < 8) stores the data word as bits [s*32+31:s*32] of matrix row r. Any nonzero `wb_sel_i` writes the whole word.
- R4: A read of 0x30000000 + a*32 raises `pkt_valid_o` for one cycle, in the cycle after the request. In that cycle `pkt_axon_o` = a and `pkt_row_o` = row a. `pkt_row_o` keeps its value until the next packet.
- R5: A read of 0x3000C001 gives a one-cycle `img_start_o` pulse, and a read of 0x3000C003 gives a one-cycle `img_end_o` pulse. Each pulse comes together with the acknowledge, and neither read raises `pkt_valid_o`.
- R6: A write to 0x30004000 + n*16 + k*4 loads record n. For k = 0 it loads bits [31:0], for k = 1 bits [63:32], and for k = 2 bits [79:64] from the low 16 data bits. The upper 16 bits of the k = 2 word are ignored.
- R7: `prm_rd_data_o` shows record `prm_rd_idx_i` one cycle after the index is presented. If a bus write to the same record lands in that same cycle, the old value is shown first and the new value one cycle later.
- R8: A read of 0x30008000 + w*4 (w < 8) returns `spike_vec_i[w*32+31:w*32]` on `wb_dat_o` in the acknowledge cycle. Every other read returns zero.
- R9: Every other access is acknowledged and has no effect on the stores and no pulse. This covers unaligned or out-of-range writes, writes with `wb_sel_i` = 0, writes to the control or spike addresses, parameter writes at word offset 12, and reads of matrix addresses whose low five bits are nonzero.
- R10: A packet read issued in the cycle right after a matrix write to the same row presents the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write when high, read when low |
| wb_sel_i | input | 4 | Byte selects; zero suppresses a write |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_ack_o | output | 1 | Acknowledge, one cycle after each request |
| wb_dat_o | output | 32 | Read data |
| spike_vec_i | input | 256 | Neuron spike vector from the core |
| prm_rd_idx_i | input | 8 | Parameter record index requested by the core |
| prm_rd_data_o | output | 80 | Parameter record, registered |
| pkt_valid_o | output | 1 | One-cycle input spike packet strobe |
| pkt_axon_o | output | 8 | Axon index of the packet |
| pkt_row_o | output | 256 | Matrix row of the packet axon |
| img_start_o | output | 1 | One-cycle image start pulse |
| img_end_o | output | 1 | One-cycle image end pulse |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a bus parameter write and the core's parameter read of the same record. The bench presents the record index on the edge that accepts a write to that record, and it expects the old record first and the new one a cycle later. The second pair is a matrix write followed directly by a packet read of the same row. Here cyc and stb stay high across two back-to-back requests, and the bench expects the freshly written word inside `pkt_row_o`, together with an acknowledge in both cycles.

// File: rtl/xbf_pkg.sv
package xbf_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_SYN_WR    = 3'd1,
    OP_PRM_WR    = 3'd2,
    OP_PKT       = 3'd3,
    OP_IMG_START = 3'd4,
    OP_IMG_END   = 3'd5,
    OP_SPK_RD    = 3'd6
  } xbf_op_e;

endpackage

// File: rtl/xbf_decode.sv
module xbf_decode
  import xbf_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int AXONS   = 256,
  parameter int NEURONS = 256,
  parameter logic [AW-1:0] SYN_BASE = 32'h3000_0000,
  parameter logic [AW-1:0] PRM_BASE = 32'h3000_4000,
  parameter logic [AW-1:0] SPK_BASE = 32'h3000_8000,
  parameter logic [AW-1:0] CTL_BASE = 32'h3000_C000,
  localparam int AXW       = $clog2(AXONS),
  localparam int NW        = $clog2(NEURONS),
  localparam int ROW_WORDS = NEURONS / DW,
  localparam int SEGW      = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1
) (
  input  logic            req,
  input  logic            we,
  input  logic [DW/8-1:0] sel,
  input  logic [AW-1:0]   adr,
  output xbf_op_e         op,
  output logic [AXW-1:0]  row,
  output logic [SEGW-1:0] seg,
  output logic [NW-1:0]   prm_idx,
  output logic [1:0]      prm_word,
  output logic [SEGW-1:0] spk_word
);

  localparam logic [AW-1:0] SYN_SPAN = AW'(AXONS * 32);
  localparam logic [AW-1:0] PRM_SPAN = AW'(NEURONS * 16);
  localparam logic [AW-1:0] SPK_SPAN = AW'(ROW_WORDS * 4);
  localparam logic [2:0]    LAST_SEG = 3'(ROW_WORDS - 1);

  logic [AW-1:0] syn_off, prm_off, spk_off;
  logic          in_syn, in_prm, in_spk;

  assign syn_off = adr - SYN_BASE;
  assign prm_off = adr - PRM_BASE;
  assign spk_off = adr - SPK_BASE;

  assign in_syn = (adr >= SYN_BASE) && (syn_off < SYN_SPAN);
  assign in_prm = (adr >= PRM_BASE) && (prm_off < PRM_SPAN);
  assign in_spk = (adr >= SPK_BASE) && (spk_off < SPK_SPAN);

  assign row      = syn_off[5 +: AXW];
  assign seg      = syn_off[2 +: SEGW];
  assign prm_idx  = prm_off[4 +: NW];
  assign prm_word = prm_off[3:2];
  assign spk_word = spk_off[2 +: SEGW];

  always_comb begin
    op = OP_NONE;
    if (req) begin
      if (we) begin
        if (sel != '0) begin
          if (in_syn && (syn_off[1:0] == 2'b00) && (syn_off[4:2] <= LAST_SEG))
            op = OP_SYN_WR;
          else if (in_prm && (prm_off[1:0] == 2'b00) && (prm_off[3:2] != 2'd3))
            op = OP_PRM_WR;
        end
      end else begin
        if (in_syn && (syn_off[4:0] == 5'd0))
          op = OP_PKT;
        else if (adr == CTL_BASE + AW'(1))
          op = OP_IMG_START;
        else if (adr == CTL_BASE + AW'(3))
          op = OP_IMG_END;
        else if (in_spk && (spk_off[1:0] == 2'b00))
          op = OP_SPK_RD;
      end
    end
  end

endmodule

// File: rtl/xbf_syn_store.sv
module xbf_syn_store #(
  parameter int DW      = 32,
  parameter int AXONS   = 256,
  parameter int NEURONS = 256,
  localparam int AXW       = $clog2(AXONS),
  localparam int ROW_WORDS = NEURONS / DW,
  localparam int SEGW      = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AXW-1:0]     wr_row,
  input  logic [SEGW-1:0]    wr_seg,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic [AXW-1:0]     rd_row,
  output logic [NEURONS-1:0] rd_data
);

  // One narrow bank per word segment so each maps onto a block RAM
  // with a word-wide write port and a shared read address.
  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_bank
    logic [DW-1:0] bank [AXONS];
    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_seg == SEGW'(g)))
        bank[wr_row] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rd_en)
        q <= bank[rd_row];
    end

    assign rd_data[g*DW +: DW] = q;
  end

  // R3/R4: a single bus request is either a write or a packet read.
  a_r4_no_wr_and_rd: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

endmodule

// File: rtl/xbf_prm_store.sv
module xbf_prm_store #(
  parameter int DW      = 32,
  parameter int NEURONS = 256,
  parameter int PRM_W   = 80,
  localparam int NW   = $clog2(NEURONS),
  localparam int HI_W = PRM_W - 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NW-1:0]    wr_idx,
  input  logic [1:0]       wr_word,
  input  logic [DW-1:0]    wr_data,
  input  logic [NW-1:0]    rd_idx,
  output logic [PRM_W-1:0] rd_data
);

  logic [DW-1:0]   lo_mem  [NEURONS];
  logic [DW-1:0]   mid_mem [NEURONS];
  logic [HI_W-1:0] hi_mem  [NEURONS];

  logic [DW-1:0]   lo_q, mid_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (wr_en && (wr_word == 2'd0)) lo_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && (wr_word == 2'd1)) mid_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && (wr_word == 2'd2)) hi_mem[wr_idx] <= wr_data[HI_W-1:0];
  end

  // Read-first registered read on every cycle.
  always_ff @(posedge clk) begin
    lo_q  <= lo_mem[rd_idx];
    mid_q <= mid_mem[rd_idx];
    hi_q  <= hi_mem[rd_idx];
  end

  assign rd_data = {hi_q, mid_q, lo_q};

  // R6: only the three record words are ever written.
  a_r6_word_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_word != 2'd3));

endmodule

// File: rtl/xbar_bus_frontend.sv
module xbar_bus_frontend
  import xbf_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int AXONS   = 256,
  parameter int NEURONS = 256,
  parameter int PRM_W   = 80,
  parameter logic [AW-1:0] SYN_BASE = 32'h3000_0000,
  parameter logic [AW-1:0] PRM_BASE = 32'h3000_4000,
  parameter logic [AW-1:0] SPK_BASE = 32'h3000_8000,
  parameter logic [AW-1:0] CTL_BASE = 32'h3000_C000,
  localparam int AXW       = $clog2(AXONS),
  localparam int NW        = $clog2(NEURONS),
  localparam int ROW_WORDS = NEURONS / DW,
  localparam int SEGW      = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [DW/8-1:0]    wb_sel_i,
  input  logic [AW-1:0]      wb_adr_i,
  input  logic [DW-1:0]      wb_dat_i,
  output logic               wb_ack_o,
  output logic [DW-1:0]      wb_dat_o,
  input  logic [NEURONS-1:0] spike_vec_i,
  input  logic [NW-1:0]      prm_rd_idx_i,
  output logic [PRM_W-1:0]   prm_rd_data_o,
  output logic               pkt_valid_o,
  output logic [AXW-1:0]     pkt_axon_o,
  output logic [NEURONS-1:0] pkt_row_o,
  output logic               img_start_o,
  output logic               img_end_o
);

  logic            req;
  xbf_op_e         op;
  logic [AXW-1:0]  row;
  logic [SEGW-1:0] seg;
  logic [NW-1:0]   prm_idx;
  logic [1:0]      prm_word;
  logic [SEGW-1:0] spk_word;

  assign req = wb_cyc_i && wb_stb_i;

  xbf_decode #(
    .AW(AW), .DW(DW), .AXONS(AXONS), .NEURONS(NEURONS),
    .SYN_BASE(SYN_BASE), .PRM_BASE(PRM_BASE),
    .SPK_BASE(SPK_BASE), .CTL_BASE(CTL_BASE)
  ) u_dec (
    .req(req), .we(wb_we_i), .sel(wb_sel_i), .adr(wb_adr_i),
    .op(op), .row(row), .seg(seg), .prm_idx(prm_idx),
    .prm_word(prm_word), .spk_word(spk_word)
  );

  xbf_syn_store #(.DW(DW), .AXONS(AXONS), .NEURONS(NEURONS)) u_syn (
    .clk(clk), .rst(rst),
    .wr_en(op == OP_SYN_WR), .wr_row(row), .wr_seg(seg), .wr_data(wb_dat_i),
    .rd_en(op == OP_PKT), .rd_row(row), .rd_data(pkt_row_o)
  );

  xbf_prm_store #(.DW(DW), .NEURONS(NEURONS), .PRM_W(PRM_W)) u_prm (
    .clk(clk), .rst(rst),
    .wr_en(op == OP_PRM_WR), .wr_idx(prm_idx), .wr_word(prm_word),
    .wr_data(wb_dat_i), .rd_idx(prm_rd_idx_i), .rd_data(prm_rd_data_o)
  );

  logic           ack_q, pkt_q, start_q, end_q;
  logic [AXW-1:0] axon_q;
  logic [DW-1:0]  rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      pkt_q   <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      axon_q  <= '0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req;
      pkt_q   <= (op == OP_PKT);
      start_q <= (op == OP_IMG_START);
      end_q   <= (op == OP_IMG_END);
      rdata_q <= (op == OP_SPK_RD) ? spike_vec_i[spk_word*DW +: DW] : '0;
      if (op == OP_PKT)
        axon_q <= row;
    end
  end

  assign wb_ack_o    = ack_q;
  assign wb_dat_o    = rdata_q;
  assign pkt_valid_o = pkt_q;
  assign pkt_axon_o  = axon_q;
  assign img_start_o = start_q;
  assign img_end_o   = end_q;

  // R2: each request is answered in the next cycle, and only then.
  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    req |=> wb_ack_o);
  a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
    !req |=> !wb_ack_o);

  // R4: a packet strobe is always part of an acknowledged read with zero data.
  a_r4_pkt_has_ack: assert property (@(posedge clk) disable iff (rst)
    pkt_valid_o |-> (wb_ack_o && (wb_dat_o == '0)));

  // R4: the presented row only moves on a packet.
  a_r4_row_held: assert property (@(posedge clk) disable iff (rst)
    (op != OP_PKT) |=> $stable(pkt_row_o));

  // R5: control events never coincide and always ride on an acknowledge.
  a_r5_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pkt_valid_o, img_start_o, img_end_o}));
  a_r5_pulse_has_ack: assert property (@(posedge clk) disable iff (rst)
    (img_start_o || img_end_o) |-> wb_ack_o);

  // R8: read data is nonzero only in an acknowledge cycle.
  a_r8_data_only_with_ack: assert property (@(posedge clk) disable iff (rst)
    !wb_ack_o |-> (wb_dat_o == '0));

endmodule

// File: tb/sim_xbar_bus_frontend.sv
`timescale 1ns / 1ps
module sim_xbar_bus_frontend;

  localparam logic [31:0] SYN = 32'h3000_0000;
  localparam logic [31:0] PRM = 32'h3000_4000;
  localparam logic [31:0] SPK = 32'h3000_8000;
  localparam logic [31:0] CTL = 32'h3000_C000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0]   sel = 4'h0;
  logic [31:0]  adr = '0, wdat = '0;
  logic         ack;
  logic [31:0]  rdat;
  logic [255:0] spk = '0;
  logic [7:0]   pidx = '0;
  logic [79:0]  pdata;
  logic         pkt_v, istart, iend;
  logic [7:0]   paxon;
  logic [255:0] prow;

  always #2 clk = ~clk;

  xbar_bus_frontend u0 (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_sel_i(sel), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_ack_o(ack),
    .wb_dat_o(rdat), .spike_vec_i(spk), .prm_rd_idx_i(pidx),
    .prm_rd_data_o(pdata), .pkt_valid_o(pkt_v), .pkt_axon_o(paxon),
    .pkt_row_o(prow), .img_start_o(istart), .img_end_o(iend)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic         g_ack, g_pkt, g_st, g_en;
  logic [7:0]   g_axon;
  logic [255:0] g_row;
  logic [31:0]  g_dat;
  logic [79:0]  prm_model [256];

  function automatic logic [31:0] synw(int r, int s);
    return (32'(r) * 32'h9E37_79B1) ^ (32'(s) * 32'h85EB_CA77) ^ 32'h0F0F_1234;
  endfunction

  function automatic logic [255:0] rowx(int r);
    logic [255:0] v;
    for (int s = 0; s < 8; s++) v[s*32 +: 32] = synw(r, s);
    return v;
  endfunction

  function automatic logic [31:0] prmw(int n, int k);
    return (32'(n) * 32'hC2B2_AE35) + (32'(k) * 32'h27D4_EB2F) + 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [31:0] a, input logic w, input logic [31:0] d,
                     input logic [3:0] s);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; sel = s;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0; sel = 4'h0;
    g_ack = ack; g_pkt = pkt_v; g_st = istart; g_en = iend;
    g_axon = paxon; g_row = prow; g_dat = rdat;
  endtask

  task automatic quiet_ok(input string req);
    chk(g_ack == 1'b1, req, 256'(g_ack), 256'd1);
    chk({g_pkt, g_st, g_en} == 3'b000, req, 256'({g_pkt, g_st, g_en}), 256'd0);
    chk(g_dat == 32'd0, req, 256'(g_dat), 256'd0);
  endtask

  task automatic pkt_ok(input int r, input logic [255:0] exp, input string req);
    bus(SYN + 32'(r) * 32, 1'b0, '0, 4'hF);
    chk(g_pkt && g_ack, req, 256'({g_pkt, g_ack}), 256'd3);
    chk(g_axon == 8'(r), req, 256'(g_axon), 256'(r));
    chk(g_row == exp, req, g_row, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, and a request during reset gets no acknowledge
    repeat (2) @(negedge clk);
    cyc = 1'b1; stb = 1'b1; adr = CTL + 32'd1;
    @(negedge clk);
    chk({ack, pkt_v, istart, iend} == 4'b0, "R1", 256'({ack, pkt_v, istart, iend}), 256'd0);
    chk(rdat == 32'd0 && paxon == 8'd0, "R1", 256'({rdat, paxon}), 256'd0);
    cyc = 1'b0; stb = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk({ack, pkt_v, istart, iend} == 4'b0, "R1", 256'({ack, pkt_v, istart, iend}), 256'd0);

    // R3: load the whole matrix
    for (int r = 0; r < 256; r++)
      for (int s = 0; s < 8; s++)
        bus(SYN + 32'(r) * 32 + 32'(s) * 4, 1'b1, synw(r, s), (s % 2 == 1) ? 4'h1 : 4'hF);
    chk(g_ack == 1'b1, "R2", 256'(g_ack), 256'd1);
    @(negedge clk);
    chk(ack == 1'b0, "R2", 256'(ack), 256'd0);

    // R4: one packet per axon, every row checked
    for (int r = 0; r < 256; r++) pkt_ok(r, rowx(r), "R4");
    @(negedge clk);
    chk(pkt_v == 1'b0 && ack == 1'b0, "R4", 256'({pkt_v, ack}), 256'd0);
    chk(prow == rowx(255), "R4", prow, rowx(255));

    // R6: load all parameter records, third word carries junk above bit 15
    for (int n = 0; n < 256; n++) begin
      bus(PRM + 32'(n) * 16,      1'b1, prmw(n, 0), 4'hF);
      bus(PRM + 32'(n) * 16 + 4,  1'b1, prmw(n, 1), 4'hF);
      bus(PRM + 32'(n) * 16 + 8,  1'b1, prmw(n, 2), 4'hF);
      prm_model[n] = {prmw(n, 2)[15:0], prmw(n, 1), prmw(n, 0)};
    end
    // R7: registered read port sweep
    for (int n = 0; n < 256; n++) begin
      @(negedge clk); pidx = 8'(n);
      @(negedge clk);
      chk(pdata == prm_model[n], "R6", 256'(pdata), 256'(prm_model[n]));
    end

    // R7: same-cycle write and read of record 5
    @(negedge clk);
    pidx = 8'd5;
    cyc = 1'b1; stb = 1'b1; we = 1'b1; sel = 4'hF; adr = PRM + 32'd80; wdat = 32'hA5A5_0F0F;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    chk(pdata == prm_model[5], "R7", 256'(pdata), 256'(prm_model[5]));
    prm_model[5][31:0] = 32'hA5A5_0F0F;
    @(negedge clk);
    chk(pdata == prm_model[5], "R7", 256'(pdata), 256'(prm_model[5]));

    // R5: image start and end pulses
    bus(CTL + 32'd1, 1'b0, '0, 4'hF);
    chk({g_ack, g_st, g_en, g_pkt} == 4'b1100, "R5", 256'({g_ack, g_st, g_en, g_pkt}), 256'hC);
    @(negedge clk);
    chk(istart == 1'b0, "R5", 256'(istart), 256'd0);
    bus(CTL + 32'd3, 1'b0, '0, 4'hF);
    chk({g_ack, g_st, g_en, g_pkt} == 4'b1010, "R5", 256'({g_ack, g_st, g_en, g_pkt}), 256'hA);
    @(negedge clk);
    chk(iend == 1'b0, "R5", 256'(iend), 256'd0);

    // R8: spike window words
    for (int w = 0; w < 8; w++) spk[w*32 +: 32] = (32'(w) * 32'h1111_1111) ^ 32'h5A00_00A5;
    for (int w = 0; w < 8; w++) begin
      bus(SPK + 32'(w) * 4, 1'b0, '0, 4'hF);
      chk(g_dat == spk[w*32 +: 32], "R8", 256'(g_dat), 256'(spk[w*32 +: 32]));
    end
    bus(PRM, 1'b0, '0, 4'hF);
    quiet_ok("R8");
    bus(SPK + 32'd32, 1'b0, '0, 4'hF);
    quiet_ok("R8");

    // R9: accesses with no effect
    bus(SYN + 32'd34, 1'b1, 32'hDEAD_0001, 4'hF); quiet_ok("R9");
    bus(SYN + 32'h2000, 1'b1, 32'hDEAD_0002, 4'hF); quiet_ok("R9");
    bus(CTL + 32'd1, 1'b1, 32'hDEAD_0003, 4'hF); quiet_ok("R9");
    bus(SPK, 1'b1, 32'hDEAD_0004, 4'hF); quiet_ok("R9");
    bus(SYN + 32'd68, 1'b1, 32'hDEAD_0005, 4'h0); quiet_ok("R9");
    bus(PRM + 32'd12, 1'b1, 32'hDEAD_0006, 4'hF); quiet_ok("R9");
    bus(SYN + 32'd4, 1'b0, '0, 4'hF); quiet_ok("R9");
    bus(CTL + 32'd2, 1'b0, '0, 4'hF); quiet_ok("R9");
    pkt_ok(1, rowx(1), "R9");
    pkt_ok(2, rowx(2), "R9");
    pkt_ok(0, rowx(0), "R9");
    @(negedge clk); pidx = 8'd0;
    @(negedge clk);
    chk(pdata == prm_model[0], "R9", 256'(pdata), 256'(prm_model[0]));

    // R10: write row 7 word 3, packet read of row 7 in the very next cycle
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; sel = 4'hF; adr = SYN + 32'd236; wdat = 32'hCAFE_F00D;
    @(negedge clk);
    we = 1'b0; adr = SYN + 32'd224;
    chk(ack == 1'b1, "R10", 256'(ack), 256'd1);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; sel = 4'h0;
    begin
      logic [255:0] e;
      e = rowx(7);
      e[96 +: 32] = 32'hCAFE_F00D;
      chk(ack && pkt_v && paxon == 8'd7, "R10", 256'({ack, pkt_v, paxon}), 256'h307);
      chk(prow == e, "R10", prow, e);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule